// File: doc/BRIEF.md
# Arbitrated Short Bus-Reset Requester

This block turns a software request into a short bus reset that is won through normal arbitration on a serial bus. A write of 1 to the request bit is accepted only when no port is entering suspend or resume. On acceptance the block does three things: it pulses a cancel line that drops any outstanding fair arbitration request, it starts a timeout timer, and it waits for a subaction gap. Once a gap is seen it raises an arbitration request and holds it until arbitration is won. A win produces a one-cycle short-reset command.

If the timeout expires before the win, the block abandons the short reset and issues a one-cycle long-reset command in its place. The timer advances only on cycles where the time-base input `tick` is high. Its limit is a parameter, and the default corresponds to about 300 µs at 250 MHz when `tick` is tied high.

The request bit has no storage on the read side and always reads back as 0. The wire-level arbitration signalling, the reset sequence that follows either command, and fair-request generation all live outside this block.

Top module: `bus_reset_req`

## Requirements
- R1: In the idle state, a cycle with `req_wr`=1, `req_wdata`=1 and every bit of `port_busy` at 0 accepts a request. From the next cycle the request is pending and waits for a gap.
- R2: A write while any bit of `port_busy` is 1, or a write with `req_wdata`=0, is ignored. The block stays idle, and no cancel pulse or arbitration request follows.
- R3: `fair_cancel` is high for exactly the one cycle after the cycle in which a request is accepted, and at no other time.
- R4: `arb_req` rises only in the cycle after a cycle in which the block was waiting and `gap_seen` was 1. It stays high until arbitration is won or the timeout expires.
- R5: When `arb_won`=1 while `arb_req` is high, `short_rst` is high for exactly the next cycle, and then the block is idle. A win takes priority over a timeout that expires in the same cycle.
- R6: The timer clears on acceptance and counts the `tick`=1 cycles spent waiting or arbitrating. Once the count reaches TIMEOUT_TICKS and there is no win, `long_rst` is high for exactly the next cycle instead of any short reset. Expiry takes priority over a gap seen in the same cycle.
- R7: A write of 1 while a request is pending or a reset command is being issued has no effect: it does not restart the timer and produces no second cancel pulse.
- R8: `req_rdata` reads as 0 at all times.
- R9: `arb_won` outside the arbitrating state and `gap_seen` in the idle state are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_wr | input | 1 | Write strobe for the request bit |
| req_wdata | input | 1 | Value written to the request bit |
| port_busy | input | NPORTS | Per-port entry to suspend or resume in progress |
| gap_seen | input | 1 | Subaction gap detected |
| arb_won | input | 1 | Arbitration won |
| tick | input | 1 | Time-base enable for the timeout timer |
| arb_req | output | 1 | Arbitration request for the short reset |
| fair_cancel | output | 1 | One-cycle pulse that abandons an outstanding fair request |
| short_rst | output | 1 | One-cycle short bus-reset command |
| long_rst | output | 1 | One-cycle long bus-reset command |
| req_rdata | output | 1 | Read value of the request bit |

## Verification
The bench builds the block with NPORTS=4 and TIMEOUT_TICKS=12. A limit this short makes expiry reachable within a few dozen cycles, so it can be exercised both while waiting for a gap and while arbitrating. It also makes it practical to land a win, or a gap, on exactly the expiry cycle. Four ports let the bench block a request with a busy flag on a port other than port 0, including the highest port. Stretches with `tick` held low show that the timer counts time-base pulses and not raw clocks.

// File: rtl/brr_pkg.sv
// Package: shared state encoding for the short bus-reset requester.
// Assumes nothing beyond a single clock domain.
package brr_pkg;
    typedef enum logic [2:0] {
        BRR_IDLE     = 3'd0,
        BRR_WAITGAP  = 3'd1,
        BRR_ARB      = 3'd2,
        BRR_SHORT    = 3'd3,
        BRR_LONG     = 3'd4
    } brr_state_e;
endpackage

// File: rtl/brr_timeout.sv
// Module: brr_timeout
// Counts time-base pulses while a request is pending and flags expiry.
// The count saturates at LIMIT. Assumes clear and run are never needed on the
// same cycle for different purposes; clear wins.
module brr_timeout #(
    parameter int LIMIT = 75000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic tick,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt_q;

    // Purpose: advance the saturating tick counter; clear on a new request.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (run && tick && cnt_q != LIM) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q == LIM);

    // R6: the counter never passes the limit
    a_r6_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM);

    // R6: without tick the count holds
    a_r6_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear) |=> $stable(cnt_q));
endmodule

// File: rtl/brr_fsm.sv
// Module: brr_fsm
// Sequences a software short-reset request: accept, wait for a gap,
// arbitrate, then issue a short reset on a win or a long reset on timeout.
// Assumes the write gate (no busy port) is computed by the caller.
module brr_fsm
    import brr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic accept_ok,
    input  logic gap_seen,
    input  logic arb_won,
    input  logic expired,
    output logic timer_clear,
    output logic timer_run,
    output logic arb_req,
    output logic fair_cancel,
    output logic short_rst,
    output logic long_rst
);
    brr_state_e state_q, state_d;
    logic       cancel_q;
    logic       accept;

    assign accept = (state_q == BRR_IDLE) && accept_ok;

    // Purpose: choose the next state from the current one and the inputs.
    always_comb begin
        state_d = state_q;
        case (state_q)
            BRR_IDLE:    if (accept) state_d = BRR_WAITGAP;
            BRR_WAITGAP: begin
                if (expired)       state_d = BRR_LONG;
                else if (gap_seen) state_d = BRR_ARB;
            end
            BRR_ARB: begin
                if (arb_won)      state_d = BRR_SHORT;
                else if (expired) state_d = BRR_LONG;
            end
            BRR_SHORT:   state_d = BRR_IDLE;
            BRR_LONG:    state_d = BRR_IDLE;
            default:     state_d = BRR_IDLE;
        endcase
    end

    // Purpose: hold the state and the one-cycle cancel pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= BRR_IDLE;
            cancel_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            cancel_q <= accept;
        end
    end

    assign timer_clear = accept;
    assign timer_run   = (state_q == BRR_WAITGAP) || (state_q == BRR_ARB);
    assign arb_req     = (state_q == BRR_ARB);
    assign short_rst   = (state_q == BRR_SHORT);
    assign long_rst    = (state_q == BRR_LONG);
    assign fair_cancel = cancel_q;

    // R2: a write refused in idle leaves the block idle
    a_r2_refused_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BRR_IDLE && !accept_ok) |=> (state_q == BRR_IDLE));

    // R3: the cancel pulse follows an accepted request
    a_r3_cancel_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        fair_cancel |-> (state_q == BRR_WAITGAP));

    // R4: arbitration begins only after a gap in the wait state
    a_r4_arb_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_req) |-> ($past(gap_seen) && $past(state_q) == BRR_WAITGAP));

    // R5: a short reset is a single-cycle pulse that follows a win
    a_r5_short_single: assert property (@(posedge clk) disable iff (!rst_n)
        short_rst |=> !short_rst);
    a_r5_short_after_win: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(short_rst) |-> $past(arb_won));

    // R6: a long reset is a single-cycle pulse that follows expiry
    a_r6_long_after_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        long_rst |-> $past(expired));
    a_r6_long_single: assert property (@(posedge clk) disable iff (!rst_n)
        long_rst |=> !long_rst);

    // R5/R6: at most one of the command outputs at a time
    a_r5_exclusive_cmds: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arb_req, short_rst, long_rst}));
endmodule

// File: rtl/bus_reset_req.sv
// Module: bus_reset_req (top)
// Software-initiated short bus-reset requester. Gates the request write on
// the per-port suspend/resume status, sequences arbitration through brr_fsm,
// and bounds the wait with brr_timeout. The request bit reads back as 0.
// Assumes all inputs are synchronous to clk.
module bus_reset_req #(
    parameter int NPORTS        = 3,
    parameter int TIMEOUT_TICKS = 75000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_wr,
    input  logic              req_wdata,
    input  logic [NPORTS-1:0] port_busy,
    input  logic              gap_seen,
    input  logic              arb_won,
    input  logic              tick,
    output logic              arb_req,
    output logic              fair_cancel,
    output logic              short_rst,
    output logic              long_rst,
    output logic              req_rdata
);
    logic any_busy;
    logic accept_ok;
    logic timer_clear;
    logic timer_run;
    logic expired;

    assign any_busy  = |port_busy;
    assign accept_ok = req_wr && req_wdata && !any_busy;
    assign req_rdata = 1'b0;

    brr_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_ok   (accept_ok),
        .gap_seen    (gap_seen),
        .arb_won     (arb_won),
        .expired     (expired),
        .timer_clear (timer_clear),
        .timer_run   (timer_run),
        .arb_req     (arb_req),
        .fair_cancel (fair_cancel),
        .short_rst   (short_rst),
        .long_rst    (long_rst)
    );

    brr_timeout #(
        .LIMIT (TIMEOUT_TICKS)
    ) u_timeout (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (timer_clear),
        .run     (timer_run),
        .tick    (tick),
        .expired (expired)
    );

    // R7: a pending request is not restarted by a further write
    a_r7_no_recancel: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_req || short_rst || long_rst) |=> !fair_cancel);
endmodule

// File: tb/bus_reset_req_bench.sv
module bus_reset_req_bench;
    localparam int NP = 4;
    localparam int TO = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_wr = 1'b0, req_wdata = 1'b0;
    logic [NP-1:0] port_busy = '0;
    logic          gap_seen = 1'b0, arb_won = 1'b0, tick = 1'b1;
    logic          arb_req, fair_cancel, short_rst, long_rst, req_rdata;

    int checks = 0;
    int errors = 0;

    // reference model state: 0 idle, 1 waiting, 2 arbitrating, 3 short, 4 long
    int m_st = 0;
    int m_cnt = 0;
    bit m_cancel = 0;

    always #2 clk = ~clk;

    bus_reset_req #(.NPORTS(NP), .TIMEOUT_TICKS(TO)) u_bus_reset_req (
        .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_wdata(req_wdata),
        .port_busy(port_busy), .gap_seen(gap_seen), .arb_won(arb_won),
        .tick(tick), .arb_req(arb_req), .fair_cancel(fair_cancel),
        .short_rst(short_rst), .long_rst(long_rst), .req_rdata(req_rdata)
    );

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural model advanced on each rising edge
    always @(posedge clk) begin
        int  nst;
        bit  exp;
        bit  acc;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_cancel = 0;
        end else begin
            exp = (m_cnt == TO);
            acc = (m_st == 0) && req_wr && req_wdata && (port_busy == 0);
            nst = m_st;
            case (m_st)
                0: if (acc) nst = 1;
                1: if (exp) nst = 4; else if (gap_seen) nst = 2;
                2: if (arb_won) nst = 3; else if (exp) nst = 4;
                default: nst = 0;
            endcase
            if (acc) m_cnt = 0;
            else if ((m_st == 1 || m_st == 2) && tick && m_cnt < TO) m_cnt++;
            m_cancel = acc;
            m_st = nst;
        end
    end

    // compare every cycle, away from the rising edge
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            check("R3 fair_cancel", fair_cancel, m_cancel);
            check("R4 arb_req", arb_req, m_st == 2);
            check("R5 short_rst", short_rst, m_st == 3);
            check("R6 long_rst", long_rst, m_st == 4);
            check("R8 req_rdata", req_rdata, 1'b0);
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write1(logic d);
        req_wr = 1'b1; req_wdata = d;
        step(1);
        req_wr = 1'b0; req_wdata = 1'b0;
    endtask

    initial begin : watchdog
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        #1;
        check("R8 reset state arb_req", arb_req, 1'b0);
        check("R8 reset state short/long", short_rst | long_rst | fair_cancel, 1'b0);
        rst_n = 1'b1;
        step(2);

        // R1 R3 R4 R5: normal short reset
        write1(1'b1);
        #1 check("R3 cancel after accept", fair_cancel, 1'b1);
        step(3);
        gap_seen = 1'b1; step(1); gap_seen = 1'b0;
        #1 check("R4 arb_req after gap", arb_req, 1'b1);
        step(3);
        arb_won = 1'b1; step(1); arb_won = 1'b0;
        #1 check("R5 short pulse", short_rst, 1'b1);
        step(3);

        // R2: busy on the highest port blocks, zero write ignored
        port_busy = 4'b1000; write1(1'b1); port_busy = '0;
        #1 check("R2 busy write no cancel", fair_cancel, 1'b0);
        write1(1'b0);
        gap_seen = 1'b1; step(2); gap_seen = 1'b0;
        #1 check("R2 blocked write stays idle", arb_req, 1'b0);

        // R9: win in idle and in wait ignored
        arb_won = 1'b1; step(2);
        write1(1'b1); step(2); arb_won = 1'b0;
        #1 check("R9 win in wait ignored", short_rst, 1'b0);
        // R6: timeout while waiting
        step(TO);
        step(4);

        // R6 with gated tick, timeout in arbitration; R7 rewrites ignored
        write1(1'b1);
        gap_seen = 1'b1; step(1); gap_seen = 1'b0;
        for (int i = 0; i < 30; i++) begin
            tick = (i % 3 == 0);
            if (i == 5 || i == 9) begin
                req_wr = 1'b1; req_wdata = 1'b1;
            end else begin
                req_wr = 1'b0; req_wdata = 1'b0;
            end
            step(1);
        end
        tick = 1'b1; req_wr = 1'b0; req_wdata = 1'b0;
        step(3);

        // R5: win in the expiry cycle beats timeout
        write1(1'b1);
        gap_seen = 1'b1; step(1); gap_seen = 1'b0;
        step(TO - 1);
        arb_won = 1'b1; step(1); arb_won = 1'b0;
        #1 check("R5 win beats expiry", short_rst, 1'b1);
        step(3);

        // R6: gap in the expiry cycle, expiry wins
        write1(1'b1);
        step(TO);
        gap_seen = 1'b1; step(1); gap_seen = 1'b0;
        #1 check("R6 expiry beats gap", long_rst, 1'b1);
        step(3);

        // mixed pseudo-random traffic against the model
        begin
            logic [15:0] lf = 16'hACE1;
            for (int i = 0; i < 3000; i++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                req_wr    = lf[0] & lf[3];
                req_wdata = lf[1] | lf[7];
                port_busy = (lf[5:2] == 4'd0) ? lf[11:8] : 4'd0;
                gap_seen  = lf[4] & lf[9] & lf[12];
                arb_won   = lf[6] & lf[10] & lf[13] & lf[2];
                tick      = lf[14] | lf[8];
                step(1);
            end
        end
        req_wr = 0; port_busy = '0; gap_seen = 0; arb_won = 0; tick = 1;
        step(TO + 4);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule